// File: doc/BRIEF.md
# Write-with-auto-precharge sequencer

This block sits on the controller side of a DDR2-style SDRAM and runs one complete write on a single bank. The write closes its own row. A request carries a bank, a row, a column, four data words and a per-beat mask, and is accepted over a ready/valid port. The block then opens the row, waits the row-to-column delay, and issues a WRITE that asks the device to precharge automatically. It then drives the burst with its data strobe, mask and output enables at the write latency. After that it keeps the bank busy until the device has finished its internal precharge.

All timing values are parameters counted in clock cycles. The double-rate data lines are shown as two values per controller cycle: the half after the rising edge and the half after the falling edge. The physical layer serialises them. No precharge command is ever issued. The busy window runs from the last data beat through write recovery and precharge time, and it is never shorter than the minimum time a row must stay open.

Top module: `wap_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, req_ready is 1, the command is NOP, cke is 1 and both dq_oe and dqs_oe are 0.
- R2: A request accepted with req_valid and req_ready both high at a rising edge puts ACTIVATE on the command pins in the following cycle, with req_row on addr and req_bank on ba.
- R3: WRITE appears exactly T_RCD cycles after ACTIVATE. It carries the same bank, the column on addr[CW-1:0] and addr[10] = 1 as the auto-precharge flag.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as ACTIVATE = 0011, WRITE = 0100 and NOP = 0111. Every cycle that is neither ACTIVATE nor WRITE is NOP, and cke stays 1.
- R5: In the cycle before the first data cycle (T_RCD+WL-1 after ACTIVATE), dqs_oe is 1, dqs_r and dqs_f are 0, and dq_oe is 0. This is the preamble.
- R6: In the two data cycles starting at T_RCD+WL after ACTIVATE, dq_oe and dqs_oe are 1, dqs_r = 1 and dqs_f = 0. Word k of the request is req_data[k*DW +: DW]. Words 0 and 1 appear on dq_r and dq_f in the first data cycle, and words 2 and 3 in the second.
- R7: Mask bit k (req_mask[k]) drives the DM value of beat k, on dm_r for even beats and dm_f for odd beats.
- R8: In the cycle after the last data cycle, dqs_oe is 1, dqs_r and dqs_f are 0, and dq_oe is 0. This is the postamble. In every other cycle both enables are 0, and dq_oe never goes high without dqs_oe.
- R9: req_ready is 0 from the ACTIVATE cycle until GAP-2 cycles after it, and 1 in cycle GAP-1, where GAP = max(T_RCD+WL+2+T_WR, T_RAS) + T_RP. A request held waiting therefore produces the next ACTIVATE exactly GAP cycles after the previous one.
- R10: A req_valid raised while req_ready is 0 is ignored: the burst in flight keeps the first request's data, and no extra ACTIVATE appears.
- R11: When T_RAS is larger than T_RCD+WL+2+T_WR, T_RAS sets the busy window, so req_ready first returns T_RAS+T_RP-1 cycles after ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Bank idle, request can be taken |
| req_row | input | AW | Row address |
| req_col | input | CW | Column address of the first beat |
| req_bank | input | BW | Bank address |
| req_data | input | 4*DW | Four burst words, word k at k*DW |
| req_mask | input | 4 | Per-beat mask, bit k for beat k |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BW | Bank address pins |
| addr | output | AW | Address pins |
| dq_r | output | DW | Data, rising-edge half |
| dq_f | output | DW | Data, falling-edge half |
| dm_r | output | 1 | Mask, rising-edge half |
| dm_f | output | 1 | Mask, falling-edge half |
| dqs_r | output | 1 | Strobe level, first half-cycle |
| dqs_f | output | 1 | Strobe level, second half-cycle |
| dq_oe | output | 1 | Data and mask output enable |
| dqs_oe | output | 1 | Strobe output enable |

## Verification
The properties assume that reset is high at the start, that CW is at most 10 with AW at least 11 so the column never reaches the flag bit, and that WL and every timing value are at least 1. The bench keeps within these limits by using the default widths on both instances. It also raises req_valid while the bank is busy, which the properties must tolerate: they tie ACTIVATE only to a real valid-and-ready handshake and measure the spacing from the previous ACTIVATE. The bench then queues requests back to back in the very cycle ready returns, so the spacing properties are tested at their tightest.

// File: rtl/wap_pkg.sv
package wap_pkg;

    localparam int BURST_LEN = 4;
    localparam int DATA_CYC  = BURST_LEN / 2;
    localparam int AP_BIT    = 10;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_WRITE
    } cmd_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic pins_t encode_cmd(cmd_e c);
        pins_t p;
        case (c)
            CMD_ACT:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_WRITE: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            default:   p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // cycles from one ACTIVATE to the earliest next ACTIVATE
    function automatic int gap_cycles(int rcd, int wl, int wr, int ras, int rp);
        return max2(rcd + wl + DATA_CYC + wr, ras) + rp;
    endfunction

endpackage

// File: rtl/wap_ctrl.sv
module wap_ctrl
    import wap_pkg::*;
#(
    parameter int AW   = 14,
    parameter int CW   = 10,
    parameter int BW   = 3,
    parameter int DW   = 8,
    parameter int GAP  = 13,
    parameter int CNTW = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [AW-1:0]               req_row,
    input  logic [CW-1:0]               req_col,
    input  logic [BW-1:0]               req_bank,
    input  logic [BURST_LEN*DW-1:0]     req_data,
    input  logic [BURST_LEN-1:0]        req_mask,
    output logic                        busy,
    output logic [CNTW-1:0]             cnt,
    output logic [AW-1:0]               row_q,
    output logic [CW-1:0]               col_q,
    output logic [BW-1:0]               bank_q,
    output logic [BURST_LEN*DW-1:0]     data_q,
    output logic [BURST_LEN-1:0]        mask_q
);

    localparam logic [CNTW-1:0] LAST_BUSY = CNTW'(GAP - 2);

    state_e          st_q;
    logic [CNTW-1:0] cnt_q;
    logic            take;

    assign req_ready = (st_q == ST_IDLE);
    assign take      = req_valid && req_ready;
    assign busy      = (st_q == ST_BUSY);
    assign cnt       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        st_q  <= ST_BUSY;
                        cnt_q <= '0;
                    end
                end
                default: begin
                    if (cnt_q == LAST_BUSY) st_q <= ST_IDLE;
                    cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            row_q  <= req_row;
            col_q  <= req_col;
            bank_q <= req_bank;
            data_q <= req_data;
            mask_q <= req_mask;
        end
    end

endmodule

// File: rtl/wap_cmd.sv
module wap_cmd
    import wap_pkg::*;
#(
    parameter int AW    = 14,
    parameter int CW    = 10,
    parameter int BW    = 3,
    parameter int CNTW  = 4,
    parameter int T_RCD = 3
) (
    input  logic            busy,
    input  logic [CNTW-1:0] cnt,
    input  logic [AW-1:0]   row_q,
    input  logic [CW-1:0]   col_q,
    input  logic [BW-1:0]   bank_q,
    output logic            cke,
    output logic            cs_n,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic [BW-1:0]   ba,
    output logic [AW-1:0]   addr
);

    cmd_e  cmd;
    pins_t pins;

    always_comb begin
        cmd = CMD_NOP;
        if (busy && cnt == '0)                 cmd = CMD_ACT;
        else if (busy && cnt == CNTW'(T_RCD))  cmd = CMD_WRITE;
    end

    always_comb begin
        addr = '0;
        ba   = '0;
        case (cmd)
            CMD_ACT: begin
                addr = row_q;
                ba   = bank_q;
            end
            CMD_WRITE: begin
                addr         = AW'(col_q);
                addr[AP_BIT] = 1'b1;
                ba           = bank_q;
            end
            default: ;
        endcase
    end

    assign pins  = encode_cmd(cmd);
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign cke   = 1'b1;

endmodule

// File: rtl/wap_dq.sv
module wap_dq
    import wap_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CNTW = 4,
    parameter int D0   = 5
) (
    input  logic                    busy,
    input  logic [CNTW-1:0]         cnt,
    input  logic [BURST_LEN*DW-1:0] data_q,
    input  logic [BURST_LEN-1:0]    mask_q,
    output logic [DW-1:0]           dq_r,
    output logic [DW-1:0]           dq_f,
    output logic                    dm_r,
    output logic                    dm_f,
    output logic                    dqs_r,
    output logic                    dqs_f,
    output logic                    dq_oe,
    output logic                    dqs_oe
);

    localparam logic [CNTW-1:0] PRE_AT  = CNTW'(D0 - 1);
    localparam logic [CNTW-1:0] POST_AT = CNTW'(D0 + DATA_CYC);

    always_comb begin
        dq_r   = '0;
        dq_f   = '0;
        dm_r   = 1'b0;
        dm_f   = 1'b0;
        dqs_r  = 1'b0;
        dqs_f  = 1'b0;
        dq_oe  = 1'b0;
        dqs_oe = busy && (cnt >= PRE_AT) && (cnt <= POST_AT);
        for (int g = 0; g < DATA_CYC; g++) begin
            if (busy && cnt == CNTW'(D0 + g)) begin
                dq_r  = data_q[(2*g)*DW +: DW];
                dq_f  = data_q[(2*g+1)*DW +: DW];
                dm_r  = mask_q[2*g];
                dm_f  = mask_q[2*g+1];
                dqs_r = 1'b1;
                dq_oe = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wap_seq.sv
module wap_seq
    import wap_pkg::*;
#(
    parameter int AW    = 14,
    parameter int CW    = 10,
    parameter int BW    = 3,
    parameter int DW    = 8,
    parameter int T_RCD = 3,
    parameter int T_RAS = 8,
    parameter int T_RP  = 3,
    parameter int T_WR  = 3,
    parameter int WL    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [AW-1:0]           req_row,
    input  logic [CW-1:0]           req_col,
    input  logic [BW-1:0]           req_bank,
    input  logic [4*DW-1:0]         req_data,
    input  logic [3:0]              req_mask,
    output logic                    cke,
    output logic                    cs_n,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n,
    output logic [BW-1:0]           ba,
    output logic [AW-1:0]           addr,
    output logic [DW-1:0]           dq_r,
    output logic [DW-1:0]           dq_f,
    output logic                    dm_r,
    output logic                    dm_f,
    output logic                    dqs_r,
    output logic                    dqs_f,
    output logic                    dq_oe,
    output logic                    dqs_oe
);

    localparam int GAP  = gap_cycles(T_RCD, WL, T_WR, T_RAS, T_RP);
    localparam int CNTW = $clog2(GAP + 1);
    localparam int D0   = T_RCD + WL;

    logic                    busy;
    logic [CNTW-1:0]         cnt;
    logic [AW-1:0]           row_q;
    logic [CW-1:0]           col_q;
    logic [BW-1:0]           bank_q;
    logic [BURST_LEN*DW-1:0] data_q;
    logic [BURST_LEN-1:0]    mask_q;

    wap_ctrl #(
        .AW(AW), .CW(CW), .BW(BW), .DW(DW), .GAP(GAP), .CNTW(CNTW)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_bank(req_bank),
        .req_data(req_data), .req_mask(req_mask),
        .busy(busy), .cnt(cnt),
        .row_q(row_q), .col_q(col_q), .bank_q(bank_q),
        .data_q(data_q), .mask_q(mask_q)
    );

    wap_cmd #(
        .AW(AW), .CW(CW), .BW(BW), .CNTW(CNTW), .T_RCD(T_RCD)
    ) u_cmd (
        .busy(busy), .cnt(cnt),
        .row_q(row_q), .col_q(col_q), .bank_q(bank_q),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );

    wap_dq #(
        .DW(DW), .CNTW(CNTW), .D0(D0)
    ) u_dq (
        .busy(busy), .cnt(cnt), .data_q(data_q), .mask_q(mask_q),
        .dq_r(dq_r), .dq_f(dq_f), .dm_r(dm_r), .dm_f(dm_f),
        .dqs_r(dqs_r), .dqs_f(dqs_f), .dq_oe(dq_oe), .dqs_oe(dqs_oe)
    );

endmodule

// File: rtl/wap_seq_chk.sv
module wap_seq_chk #(
    parameter int T_RCD = 3,
    parameter int GAP   = 13,
    parameter int AW    = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          cke,
    input logic          cs_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic          dq_oe,
    input logic          dqs_oe,
    input logic          dqs_r,
    input logic          dqs_f
);

    logic        is_act;
    logic        is_wr;
    logic [15:0] since_q;   // cycles since the last ACTIVATE, minus one

    assign is_act = !cs_n && !ras_n && cas_n && we_n;
    assign is_wr  = !cs_n && ras_n && !cas_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst)                   since_q <= '1;
        else if (is_act)           since_q <= '0;
        else if (since_q != '1)    since_q <= since_q + 1'b1;
    end

    assert_act_follows_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> is_act);

    assert_write_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        is_wr |-> (since_q == 16'(T_RCD - 1)));

    assert_write_autopre_R3: assert property (@(posedge clk) disable iff (rst)
        is_wr |-> addr[10]);

    assert_cke_select_R4: assert property (@(posedge clk) disable iff (rst)
        cke && !cs_n);

    assert_strobe_shape_R6: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (dqs_r && !dqs_f));

    assert_dq_inside_dqs_R8: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe);

    assert_act_gap_R9: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_q >= 16'(GAP - 1)));

    assert_busy_on_act_R9: assert property (@(posedge clk) disable iff (rst)
        is_act |-> !req_ready);

endmodule

bind wap_seq wap_seq_chk #(
    .T_RCD(T_RCD), .GAP(GAP), .AW(AW)
) u_wap_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_r(dqs_r), .dqs_f(dqs_f)
);

// File: tb/test_wap_seq.sv
module test_wap_seq;

    localparam int AW = 14, CW = 10, BW = 3, DW = 8;
    localparam int TRCD = 3, TRAS = 8, TRP = 3, TWR = 3, WLAT = 2;
    localparam int D0   = TRCD + WLAT;
    localparam int GAP  = ((D0 + 2 + TWR) > TRAS ? (D0 + 2 + TWR) : TRAS) + TRP;
    localparam int TRAS2 = 14;
    localparam int GAP2  = TRAS2 + TRP;
    localparam int NV    = 4;

    typedef struct packed {
        logic [AW-1:0]   row;
        logic [CW-1:0]   col;
        logic [BW-1:0]   bank;
        logic [4*DW-1:0] data;
        logic [3:0]      mask;
        logic            poke;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{14'h1A2B, 10'h3F0, 3'd5, 32'hDEADBEEF, 4'b0000, 1'b0},
        '{14'h0001, 10'h004, 3'd0, 32'h01234567, 4'b1010, 1'b0},
        '{14'h3FFF, 10'h3FF, 3'd7, 32'hA5C33CF0, 4'b0101, 1'b1},
        '{14'h2000, 10'h000, 3'd2, 32'h80FF7F00, 4'b1111, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_valid2 = 1'b0;
    logic [AW-1:0]   req_row  = '0;
    logic [CW-1:0]   req_col  = '0;
    logic [BW-1:0]   req_bank = '0;
    logic [4*DW-1:0] req_data = '0;
    logic [3:0]      req_mask = '0;

    logic req_ready, cke, cs_n, ras_n, cas_n, we_n, dm_r, dm_f, dqs_r, dqs_f, dq_oe, dqs_oe;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_r, dq_f;

    logic req_ready2, cke2, cs_n2, ras_n2, cas_n2, we_n2, dm_r2, dm_f2, dqs_r2, dqs_f2, dq_oe2, dqs_oe2;
    logic [BW-1:0] ba2;
    logic [AW-1:0] addr2;
    logic [DW-1:0] dq_r2, dq_f2;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wap_seq i_wap_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_bank(req_bank),
        .req_data(req_data), .req_mask(req_mask),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dq_r(dq_r), .dq_f(dq_f), .dm_r(dm_r), .dm_f(dm_f),
        .dqs_r(dqs_r), .dqs_f(dqs_f), .dq_oe(dq_oe), .dqs_oe(dqs_oe)
    );

    wap_seq #(.T_RAS(TRAS2)) i_wap_seq_ras (
        .clk(clk), .rst(rst), .req_valid(req_valid2), .req_ready(req_ready2),
        .req_row(req_row), .req_col(req_col), .req_bank(req_bank),
        .req_data(req_data), .req_mask(req_mask),
        .cke(cke2), .cs_n(cs_n2), .ras_n(ras_n2), .cas_n(cas_n2), .we_n(we_n2),
        .ba(ba2), .addr(addr2), .dq_r(dq_r2), .dq_f(dq_f2), .dm_r(dm_r2), .dm_f(dm_f2),
        .dqs_r(dqs_r2), .dqs_f(dqs_f2), .dq_oe(dq_oe2), .dqs_oe(dqs_oe2)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic drive(input vec_t v);
        req_row  = v.row;
        req_col  = v.col;
        req_bank = v.bank;
        req_data = v.data;
        req_mask = v.mask;
    endtask

    task automatic chk_idle(input string req);
        chk(req, "ready", req_ready, 1'b1);
        chk(req, "cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(req, "cke", cke, 1'b1);
        chk(req, "enables", {dq_oe, dqs_oe}, 2'b00);
    endtask

    // Called at a negedge where ready is expected; returns at the negedge of cycle GAP-1.
    task automatic run_txn(input vec_t v);
        vec_t junk;
        junk = '{~v.row, ~v.col, ~v.bank, ~v.data, ~v.mask, 1'b0};
        chk("R9", "ready before accept", req_ready, 1'b1);
        drive(v);
        req_valid = 1'b1;
        for (int k = 0; k < GAP; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (v.poke && k == 1) begin drive(junk); req_valid = 1'b1; end  // R10 stimulus
            if (v.poke && k == GAP - 2) req_valid = 1'b0;
            // command pins
            if (k == 0) begin
                chk("R2", "ACT cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0011);
                chk("R2", "ACT row", addr, v.row);
                chk("R2", "ACT bank", ba, v.bank);
            end else if (k == TRCD) begin
                chk("R3", "WRITE cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0100);
                chk("R3", "WRITE col", addr[CW-1:0], v.col);
                chk("R3", "WRITE A10", addr[10], 1'b1);
                chk("R3", "WRITE bank", ba, v.bank);
            end else begin
                chk(v.poke ? "R10" : "R4", "NOP cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            end
            chk("R4", "cke", cke, 1'b1);
            // strobe and data
            if (k == D0 - 1) begin
                chk("R5", "preamble", {dqs_oe, dq_oe, dqs_r, dqs_f}, 4'b1000);
            end else if (k == D0 || k == D0 + 1) begin
                chk("R6", "burst strobe", {dqs_oe, dq_oe, dqs_r, dqs_f}, 4'b1110);
                chk(v.poke ? "R10" : "R6", "dq rise", dq_r, v.data[(2*(k-D0))*DW +: DW]);
                chk(v.poke ? "R10" : "R6", "dq fall", dq_f, v.data[(2*(k-D0)+1)*DW +: DW]);
                chk("R7", "dm", {dm_r, dm_f}, {v.mask[2*(k-D0)], v.mask[2*(k-D0)+1]});
            end else if (k == D0 + 2) begin
                chk("R8", "postamble", {dqs_oe, dq_oe, dqs_r, dqs_f}, 4'b1000);
            end else begin
                chk("R8", "enables off", {dqs_oe, dq_oe}, 2'b00);
            end
            chk("R9", $sformatf("ready k=%0d", k), req_ready, (k == GAP - 1));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        vec_t v2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1");             // R1: during reset
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");             // R1: first cycle after reset

        // table walk: back-to-back in the ready cycle
        for (int i = 0; i < NV; i++) run_txn(VECS[i]);

        @(negedge clk);
        chk_idle("R4");

        // R11: tRAS sets the busy window on the second instance
        v2 = VECS[1];
        drive(v2);
        req_valid2 = 1'b1;
        for (int k = 0; k < GAP2; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid2 = 1'b0;
                chk("R11", "ACT cmd", {cs_n2, ras_n2, cas_n2, we_n2}, 4'b0011);
            end
            chk("R11", $sformatf("ready k=%0d", k), req_ready2, (k == GAP2 - 1));
        end

        // R1: reset in the middle of a burst
        @(negedge clk);
        drive(VECS[3]);
        req_valid = 1'b1;
        for (int k = 0; k <= D0; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
        end
        chk("R6", "burst before reset", dq_oe, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        run_txn(VECS[0]);           // recovers after reset

        finish_run();
    end

endmodule